// File: doc/BRIEF.md
# Streaming Parallel CRC Frame Checker

The block checks a cyclic redundancy code over framed streams of data words, `DATA_W` bits per word. Frame boundaries come from three strobes: one marks the first word, one marks the last word, and one qualifies each word. Each message word updates an M-bit remainder in a single cycle. The update is a parallel network that is built at elaboration from one of six selectable generator polynomials. The last M/`DATA_W` words of a frame carry the transmitted checksum. At frame end the block compares that checksum with the remainder it has computed.

The message words leave the block with fresh framing strobes, and the checksum words are removed from the stream. The mismatch result appears together with the last message word. The result is either a single pass/fail bit or the full M-bit difference pattern, depending on a parameter. For the 24-bit type-C polynomial, an optional 24-bit identifier mask can be XORed into the comparison. This lets a receiver check checksums that the transmitter scrambled with a user identifier.

Top module: `pcrc_checker`

## Requirements
- R1: The remainder starts at zero for each frame and has no final inversion. Each word is taken most significant bit first. The generator is chosen by `CRC_KIND`: 6-bit 0x21, 11-bit 0x621, 16-bit 0x1021, 24-bit 0x864CFB, 0x800063 or 0xB2B117, each with the leading x^M term implicit.
- R2: The last M/`DATA_W` accepted words of a frame are the checksum and are never forwarded. Every earlier word is forwarded unchanged and in order on `out_data` with `out_valid` high. It appears one cycle after the word that arrives M/`DATA_W` accepted words later. `out_data` is zero whenever `out_valid` is low.
- R3: `out_start` is high with the first forwarded word of a frame. `out_end` is high with the last forwarded word, in the cycle after the frame's end word is accepted.
- R4: With `FULL_MISMATCH`=0, `err` (1 bit) is 1 when any checksum bit differs from the recomputed remainder, and 0 otherwise.
- R5: With `FULL_MISMATCH`=1, `err` (M bits) equals the recomputed remainder XOR the received checksum. The received checksum is the concatenation of the tail words, earliest word in the high bits.
- R6: When `MASK_EN`=1 and the polynomial is the 24-bit type C, `id_mask`, sampled with the end word, is also XORed into that difference. A checksum that was scrambled with the same mask then reports zero.
- R7: A cycle with `in_valid` low changes nothing, and the next cycle shows `out_valid`=0 and `out_end`=0.
- R8: Valid words that arrive outside a frame (no start since the last end) are ignored and produce no output.
- R9: A start that arrives inside an open frame abandons that frame: no further output, no end strobe and no error for it. The new frame is processed from scratch.
- R10: A frame of M/`DATA_W` words or fewer produces one cycle with `out_end`=1 and `out_valid`=0. In that cycle `err` is all ones (1 in pass/fail mode).
- R11: During and right after reset, all outputs are zero.
- R12: A frame with exactly one message word raises `out_start` and `out_end` in the same cycle as that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Incoming word, MSB first in transmission order |
| in_start | input | 1 | First word of a frame |
| in_end | input | 1 | Last word of a frame |
| in_valid | input | 1 | Word qualifier |
| id_mask | input | 24 | Identifier mask for the type-C checksum |
| out_data | output | DATA_W | Forwarded message word |
| out_start | output | 1 | First message word of a frame |
| out_end | output | 1 | Last message word, error result valid |
| out_valid | output | 1 | Forwarded word qualifier |
| err | output | FULL_MISMATCH ? M : 1 | Mismatch flag or pattern |

## Verification
Several functions can fall in the same cycle: forwarding the last message word, raising the end strobe and judging the checksum. The start and end strobes also coincide when the message is a single word. The bench provokes this with frames of exactly one message word, and with short frames where the end arrives before any word could be forwarded. A second collision is a restart, a start that lands on the cycle where the tail buffer is full. The bench judges every output on every clock against a behavioural model that keeps its own word queue and a bytewise remainder.

// File: rtl/pcrc_pkg.sv
package pcrc_pkg;
  localparam int MAX_M = 24;

  typedef enum logic [2:0] {
    CRC6, CRC11, CRC16, CRC24A, CRC24B, CRC24C
  } crc_kind_e;

  function automatic int poly_len(crc_kind_e k);
    case (k)
      CRC6:    return 6;
      CRC11:   return 11;
      CRC16:   return 16;
      default: return 24;
    endcase
  endfunction

  function automatic logic [MAX_M-1:0] poly_bits(crc_kind_e k);
    case (k)
      CRC6:    return 24'h000021;
      CRC11:   return 24'h000621;
      CRC16:   return 24'h001021;
      CRC24A:  return 24'h864CFB;
      CRC24B:  return 24'h800063;
      default: return 24'hB2B117;
    endcase
  endfunction

  function automatic logic [MAX_M-1:0] len_mask(int m);
    return MAX_M'((25'(1) << m) - 25'(1));
  endfunction

  // Bit-serial absorption of w data bits (data[w-1] first) into an m-bit remainder.
  function automatic logic [MAX_M-1:0] absorb(logic [MAX_M-1:0] rem, logic [MAX_M-1:0] data,
                                              int w, int m, logic [MAX_M-1:0] poly);
    logic [MAX_M-1:0] r;
    logic fb;
    r = rem;
    for (int i = MAX_M - 1; i >= 0; i--) begin
      if (i < w) begin
        fb = data[i] ^ r[m-1];
        r  = (r << 1) & len_mask(m);
        if (fb) r = r ^ poly;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pcrc_update.sv
module pcrc_update #(
  parameter int M = 24,
  parameter int W = 8,
  parameter logic [23:0] POLY = 24'hB2B117
) (
  input  logic [M-1:0] state,
  input  logic [W-1:0] word,
  output logic [M-1:0] next
);
  logic [M-1:0] s_term [M];
  logic [M-1:0] d_term [W];

  // Columns of the W-step transition matrix, one per state bit.
  for (genvar j = 0; j < M; j++) begin : g_scol
    localparam logic [23:0] COL = pcrc_pkg::absorb(24'(1) << j, 24'(0), W, M, POLY);
    assign s_term[j] = state[j] ? COL[M-1:0] : '0;
  end

  // Columns driven by each incoming data bit.
  for (genvar i = 0; i < W; i++) begin : g_dcol
    localparam logic [23:0] COL = pcrc_pkg::absorb(24'(0), 24'(1) << i, W, M, POLY);
    assign d_term[i] = word[i] ? COL[M-1:0] : '0;
  end

  always_comb begin
    logic [M-1:0] acc;
    acc = '0;
    for (int j = 0; j < M; j++) acc = acc ^ s_term[j];
    for (int i = 0; i < W; i++) acc = acc ^ d_term[i];
    next = acc;
  end
endmodule

// File: rtl/pcrc_tail_buf.sv
module pcrc_tail_buf #(
  parameter int W = 8,
  parameter int DEPTH = 3,
  localparam int LW = DEPTH * W,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          restart,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  oldest,
  output logic [LW-1:0] window,
  output logic          full
);
  logic [LW-1:0]   line_q;
  logic [CW-1:0]   cnt_q;
  logic [LW+W-1:0] cat;

  assign cat    = {line_q, din};
  assign window = cat[LW-1:0];
  assign oldest = line_q[LW-1 -: W];
  assign full   = (cnt_q == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      cnt_q  <= '0;
    end else if (push) begin
      line_q <= window;
      if (restart)    cnt_q <= CW'(1);
      else if (!full) cnt_q <= cnt_q + CW'(1);
    end
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_restart_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && restart) |=> !full || (DEPTH == 1));
endmodule

// File: rtl/pcrc_judge.sv
module pcrc_judge #(
  parameter int M = 24,
  parameter bit FULL = 1'b1,
  parameter bit MASK_ON = 1'b1,
  localparam int ERR_W = FULL ? M : 1
) (
  input  logic [M-1:0]     rem,
  input  logic [M-1:0]     rx,
  input  logic [23:0]      mask,
  input  logic             short_frame,
  output logic [ERR_W-1:0] err
);
  logic [M-1:0] mask_eff;
  logic [M-1:0] diff;

  if (MASK_ON) begin : g_mask
    assign mask_eff = mask[M-1:0];
  end else begin : g_nomask
    assign mask_eff = '0;
  end

  assign diff = rem ^ rx ^ mask_eff;

  if (FULL) begin : g_full
    assign err = short_frame ? {ERR_W{1'b1}} : ERR_W'(diff);
  end else begin : g_flag
    assign err = short_frame ? ERR_W'(1) : ERR_W'(|diff);
  end
endmodule

// File: rtl/pcrc_checker.sv
module pcrc_checker #(
  parameter pcrc_pkg::crc_kind_e CRC_KIND = pcrc_pkg::CRC24C,
  parameter int DATA_W = 8,
  parameter bit FULL_MISMATCH = 1'b1,
  parameter bit MASK_EN = 1'b1,
  localparam int M = pcrc_pkg::poly_len(CRC_KIND),
  localparam int ERR_W = FULL_MISMATCH ? M : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_start,
  input  logic              in_end,
  input  logic              in_valid,
  input  logic [23:0]       id_mask,
  output logic [DATA_W-1:0] out_data,
  output logic              out_start,
  output logic              out_end,
  output logic              out_valid,
  output logic [ERR_W-1:0]  err
);
  localparam int TAIL = M / DATA_W;
  localparam logic [23:0] POLY = pcrc_pkg::poly_bits(CRC_KIND);
  localparam bit MASK_ON = MASK_EN && (CRC_KIND == pcrc_pkg::CRC24C);

  if (DATA_W < 1 || DATA_W > M || (M % DATA_W) != 0) begin : g_bad_width
    $error("DATA_W must divide the polynomial length");
  end

  logic              in_frame_q, first_q;
  logic [M-1:0]      rem_q, rem_next;
  logic [DATA_W-1:0] oldest;
  logic [M-1:0]      window;
  logic              buf_full;
  logic [ERR_W-1:0]  err_calc;

  // Named events
  logic word_take, frame_open, msg_emit, frame_close, short_frame;
  assign word_take   = in_valid && (in_start || in_frame_q);
  assign frame_open  = word_take && in_start;
  assign msg_emit    = word_take && !in_start && buf_full;
  assign frame_close = word_take && in_end;
  assign short_frame = frame_close && !msg_emit;

  pcrc_tail_buf #(.W(DATA_W), .DEPTH(TAIL)) u_tail (
    .clk(clk), .rst_n(rst_n), .push(word_take), .restart(frame_open),
    .din(in_data), .oldest(oldest), .window(window), .full(buf_full)
  );

  pcrc_update #(.M(M), .W(DATA_W), .POLY(POLY)) u_update (
    .state(rem_q), .word(oldest), .next(rem_next)
  );

  pcrc_judge #(.M(M), .FULL(FULL_MISMATCH), .MASK_ON(MASK_ON)) u_judge (
    .rem(rem_next), .rx(window), .mask(id_mask), .short_frame(short_frame), .err(err_calc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      first_q    <= 1'b0;
      rem_q      <= '0;
      out_data   <= '0;
      out_start  <= 1'b0;
      out_end    <= 1'b0;
      out_valid  <= 1'b0;
      err        <= '0;
    end else begin
      if (word_take) in_frame_q <= !in_end;
      if (frame_open) begin
        rem_q   <= '0;
        first_q <= 1'b1;
      end else if (msg_emit) begin
        rem_q   <= rem_next;
        first_q <= 1'b0;
      end
      out_valid <= msg_emit;
      out_data  <= msg_emit ? oldest : '0;
      out_start <= msg_emit && first_q;
      out_end   <= frame_close;
      err       <= frame_close ? err_calc : '0;
    end
  end

  assert_start_with_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_start |-> out_valid);
  assert_quiet_after_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_end |=> !out_valid);
  assert_short_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_end && !out_valid) |-> (err != '0));
  assert_no_emit_on_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !$past(frame_open));
  assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_start && !in_frame_q) |=> (!out_valid && !out_end));
  assert_gap_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_end));
endmodule

// File: tb/pcrc_checker_bench.sv
module pcrc_checker_bench;
  timeunit 1ns; timeprecision 1ps;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic [7:0]  in_data = '0;
  logic        in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0;
  logic [23:0] id_mask = '0;

  logic [7:0]  od0, od1;
  logic        os0, oe0, ov0, os1, oe1, ov1;
  logic [23:0] err0;
  logic [0:0]  err1;

  // DUT 0: type-C 24-bit, full mismatch, mask on
  pcrc_checker #(.CRC_KIND(pcrc_pkg::CRC24C), .DATA_W(8), .FULL_MISMATCH(1'b1), .MASK_EN(1'b1))
  u_pcrc_checker (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_start(in_start), .in_end(in_end),
    .in_valid(in_valid), .id_mask(id_mask), .out_data(od0), .out_start(os0), .out_end(oe0),
    .out_valid(ov0), .err(err0));

  // DUT 1: 16-bit, pass/fail
  pcrc_checker #(.CRC_KIND(pcrc_pkg::CRC16), .DATA_W(8), .FULL_MISMATCH(1'b0), .MASK_EN(1'b0))
  u_pcrc_checker_pf (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_start(in_start), .in_end(in_end),
    .in_valid(in_valid), .id_mask(id_mask), .out_data(od1), .out_start(os1), .out_end(oe1),
    .out_valid(ov1), .err(err1));

  int n_cmp = 0, n_bad = 0;
  string cur_tag = "R11";
  bit finished = 1'b0;

  // Reference model state
  bit         inframe [2];
  bit         first   [2];
  int         hcnt    [2];
  logic [7:0] hold    [2][5];
  logic [23:0] rem    [2];
  bit         ev [2], es [2], ee [2];
  logic [7:0] ed [2];
  logic [23:0] eerr [2];

  function automatic int m_of(int id); return (id == 0) ? 24 : 16; endfunction
  function automatic logic [23:0] lim_of(int id); return (id == 0) ? 24'hFFFFFF : 24'h00FFFF; endfunction

  // Bytewise remainder: fold the byte in at the top, then eight shifts.
  function automatic logic [23:0] ref_crc(int id, logic [23:0] r, logic [7:0] b);
    int m = m_of(id);
    logic [23:0] p = (id == 0) ? 24'hB2B117 : 24'h001021;
    logic [23:0] x = r ^ (24'(b) << (m - 8));
    for (int k = 0; k < 8; k++) begin
      if (x[m-1]) x = ((x << 1) ^ p) & lim_of(id);
      else        x = (x << 1) & lim_of(id);
    end
    return x;
  endfunction

  task automatic model_step(int id, bit v, bit s, bit e, logic [7:0] d, logic [23:0] mk);
    int k = m_of(id) / 8;
    bit emitted = 1'b0;
    logic [23:0] chk, mism;
    ev[id] = 0; es[id] = 0; ee[id] = 0; ed[id] = '0; eerr[id] = '0;
    if (v && (s || inframe[id])) begin
      if (s) begin hcnt[id] = 0; rem[id] = '0; first[id] = 1; end
      hold[id][hcnt[id]] = d;
      hcnt[id]++;
      if (hcnt[id] > k) begin
        ev[id] = 1; ed[id] = hold[id][0]; es[id] = first[id]; first[id] = 0;
        rem[id] = ref_crc(id, rem[id], hold[id][0]);
        for (int x = 0; x < k; x++) hold[id][x] = hold[id][x+1];
        hcnt[id]--;
        emitted = 1'b1;
      end
      if (e) begin
        ee[id] = 1;
        if (emitted) begin
          chk = '0;
          for (int x = 0; x < k; x++) chk = (chk << 8) | 24'(hold[id][x]);
          mism = (rem[id] ^ chk ^ ((id == 0) ? mk : 24'h0)) & lim_of(id);
          eerr[id] = (id == 0) ? mism : 24'(mism != 0);
        end else begin
          eerr[id] = (id == 0) ? lim_of(id) : 24'h1;
        end
      end
      inframe[id] = !e;
    end
  endtask

  task automatic check(string what, int id, logic [23:0] act, logic [23:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s dut%0d %s: actual %h expected %h at %0t", cur_tag, id, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("out_valid R2", 0, 24'(ov0), 24'(ev[0]));
    check("out_data R2",  0, 24'(od0), 24'(ed[0]));
    check("out_start R3", 0, 24'(os0), 24'(es[0]));
    check("out_end R3",   0, 24'(oe0), 24'(ee[0]));
    check("err R5",       0, err0,     eerr[0]);
    check("out_valid R2", 1, 24'(ov1), 24'(ev[1]));
    check("out_data R2",  1, 24'(od1), 24'(ed[1]));
    check("out_start R3", 1, 24'(os1), 24'(es[1]));
    check("out_end R3",   1, 24'(oe1), 24'(ee[1]));
    check("err R4",       1, 24'(err1), eerr[1]);
  endtask

  task automatic drive(bit v, bit s, bit e, logic [7:0] d);
    in_valid = v; in_start = s; in_end = e; in_data = d;
    model_step(0, v, s, e, d, id_mask);
    model_step(1, v, s, e, d, id_mask);
    @(negedge clk);
    compare_all();
  endtask

  logic [7:0] fr [64];
  int flen;

  task automatic build_frame(int id, int nmsg, int seed, logic [23:0] scramble);
    logic [23:0] r = '0;
    int k = m_of(id) / 8;
    for (int i = 0; i < nmsg; i++) begin
      fr[i] = 8'((seed * 37 + i * 13 + 5) ^ (i << 4));
      r = ref_crc(id, r, fr[i]);
    end
    r = (r ^ scramble) & lim_of(id);
    for (int i = 0; i < k; i++) fr[nmsg + i] = 8'(r >> (8 * (k - 1 - i)));
    flen = nmsg + k;
  endtask

  task automatic send_frame(int gap_every);
    for (int i = 0; i < flen; i++) begin
      drive(1'b1, i == 0, i == flen - 1, fr[i]);
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) drive(1'b0, 1'b0, 1'b0, 8'hA5);
    end
    drive(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      inframe[i] = 0; first[i] = 0; hcnt[i] = 0; rem[i] = '0;
      ev[i] = 0; es[i] = 0; ee[i] = 0; ed[i] = '0; eerr[i] = '0;
    end
    // R11: reset state
    cur_tag = "R11";
    repeat (3) @(negedge clk);
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    cur_tag = "R1";  build_frame(0, 6, 1, 24'h0); send_frame(0);
    cur_tag = "R4";  build_frame(1, 5, 2, 24'h0); send_frame(0);
    cur_tag = "R5";  build_frame(0, 4, 3, 24'h0); fr[1] = fr[1] ^ 8'h10; send_frame(0);
    cur_tag = "R4";  build_frame(1, 4, 3, 24'h0); fr[2] = fr[2] ^ 8'h01; send_frame(0);
    cur_tag = "R6";  id_mask = 24'h5A3C91; build_frame(0, 3, 4, 24'h5A3C91); send_frame(0);
    id_mask = 24'h000001; send_frame(0);
    id_mask = 24'h0;
    cur_tag = "R7";  build_frame(0, 7, 5, 24'h0); send_frame(2);
    cur_tag = "R8";
    drive(1'b1, 1'b0, 1'b0, 8'h11); drive(1'b1, 1'b0, 1'b1, 8'h22); drive(1'b0, 1'b0, 1'b0, 8'h0);
    cur_tag = "R9";
    build_frame(0, 4, 6, 24'h0);
    for (int i = 0; i < 5; i++) drive(1'b1, i == 0, 1'b0, fr[i]);
    build_frame(1, 6, 7, 24'h0); send_frame(0);
    cur_tag = "R10";
    drive(1'b1, 1'b1, 1'b0, 8'h3C); drive(1'b1, 1'b0, 1'b1, 8'hC3); drive(1'b0, 1'b0, 1'b0, 8'h0);
    drive(1'b1, 1'b1, 1'b1, 8'h77); drive(1'b0, 1'b0, 1'b0, 8'h0);
    cur_tag = "R12"; build_frame(0, 1, 8, 24'h0); send_frame(0);
    build_frame(1, 1, 9, 24'h0); send_frame(0);
    cur_tag = "R2";  build_frame(1, 9, 10, 24'h0); send_frame(3);
    cur_tag = "R3";  build_frame(0, 2, 11, 24'h0); send_frame(1);
    repeat (3) drive(1'b0, 1'b0, 1'b0, 8'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule